// File: doc/BRIEF.md
# Cascade Start Pulse Controller

This block sits in each column driver of a chain that shares one data bus. Each chip takes a fixed-length share of the words on the bus, and the chips take their shares one after another. Two bidirectional start pins link neighbouring chips. A direction input decides which pin listens and which pin drives. The head chip of the chain has its listening pin tied high.

When the line sampling begins, a chip whose listening pin is high starts capturing at once. Every other chip waits. A chip drives a pulse towards the next chip shortly before its own share ends. The falling edge of that pulse tells the downstream chip that the upstream chip is taking its final word, so the downstream chip starts capturing on the very next bus cycle. A line strobe ends any activity and returns the chip to idle.

The block also reports a slot index for every captured word. The capture logic uses this index to place the word. The index counts upward in both shift directions, so the order in which words map to channels does not depend on direction.

Top module: `cascade_start_ctl`

## Requirements
- R1: With `dir_right` high, `sp1_oe` is 0 and `sp2_oe` is 1. Pin 1 is the start input and the next-chip pulse appears only on `sp2_out`.
- R2: With `dir_right` low, `sp1_oe` is 1 and `sp2_oe` is 0. Pin 2 is the start input and the next-chip pulse appears only on `sp1_out`.
- R3: If the start input is high at the clock edge where `sample_start` is sampled high, `capture_en` is high for exactly WINDOW cycles, starting in the next cycle.
- R4: If the start input is low at that edge, the chip waits until it sees the start input high and then low again. `capture_en` rises in the cycle after the cycle in which the low level is sampled.
- R5: While capturing, the next-chip pulse is high for exactly LEAD cycles, covering slots WINDOW-LEAD-1 to WINDOW-2. It is low during slot WINDOW-1.
- R6: After the last slot, `capture_en` and the pulse stay low until the next `sample_start`.
- R7: A `line_strobe` sampled high forces `capture_en` and the pulse low from the next cycle and cancels any waiting state.
- R8: `cap_slot` reads 0 in the first captured cycle and rises by one each captured cycle up to WINDOW-1, in both directions.
- R9: A high start input with no `sample_start` since the last strobe or reset does not start capture.
- R10: After reset, `capture_en` is 0 and both `sp1_out` and `sp2_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_right | input | 1 | Shift direction: 1 means pin 1 listens, 0 means pin 2 listens |
| line_strobe | input | 1 | Line strobe; clears all activity |
| sample_start | input | 1 | One-cycle marker; data words begin on the following cycle |
| sp1_in | input | 1 | Level received on start pin 1 |
| sp2_in | input | 1 | Level received on start pin 2 |
| sp1_out | output | 1 | Level driven on start pin 1 |
| sp1_oe | output | 1 | Drive enable of start pin 1 |
| sp2_out | output | 1 | Level driven on start pin 2 |
| sp2_oe | output | 1 | Drive enable of start pin 2 |
| capture_en | output | 1 | High in each cycle whose bus word belongs to this chip |
| cap_slot | output | $clog2(WINDOW) | Position of the current word within the chip's share |

## Verification
The bench builds a three-chip chain with WINDOW=7 and LEAD=3. With these values the pulse covers slots 3 to 5, and the handoff from one chip to the next falls well inside a short run. A whole line across the chain takes only 21 words. This makes it possible to check, cycle by cycle, that exactly one chip owns each word in both directions. The bench also checks that a strobe in the middle of a window cancels both the active chip and the chip that is already armed.

// File: rtl/cascade_start_ctl.sv
module cascade_start_ctl #(
  parameter int WINDOW = 289,
  parameter int LEAD   = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dir_right,
  input  logic                      line_strobe,
  input  logic                      sample_start,
  input  logic                      sp1_in,
  input  logic                      sp2_in,
  output logic                      sp1_out,
  output logic                      sp1_oe,
  output logic                      sp2_out,
  output logic                      sp2_oe,
  output logic                      capture_en,
  output logic [$clog2(WINDOW)-1:0] cap_slot
);
  localparam int CW = $clog2(WINDOW);
  localparam logic [CW-1:0] LAST    = CW'(WINDOW - 1);
  localparam logic [CW-1:0] P_FIRST = CW'(WINDOW - LEAD - 1);
  localparam logic [CW-1:0] P_LAST  = CW'(WINDOW - 2);

  typedef enum logic [1:0] {IDLE, WAIT, ARMED, ACTIVE} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic sp_in, pulse;

  assign sp_in = dir_right ? sp1_in : sp2_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= IDLE;
      cnt <= '0;
    end else if (line_strobe) begin
      st  <= IDLE;
      cnt <= '0;
    end else if (sample_start) begin
      st  <= sp_in ? ACTIVE : WAIT;
      cnt <= '0;
    end else begin
      case (st)
        WAIT:   if (sp_in) st <= ARMED;
        ARMED:  if (!sp_in) begin
                  st  <= ACTIVE;
                  cnt <= '0;
                end
        ACTIVE: if (cnt == LAST) begin
                  st  <= IDLE;
                  cnt <= '0;
                end else begin
                  cnt <= cnt + 1'b1;
                end
        default: st <= IDLE;
      endcase
    end
  end

  assign capture_en = (st == ACTIVE);
  assign cap_slot   = cnt;
  assign pulse      = capture_en && (cnt >= P_FIRST) && (cnt <= P_LAST);

  assign sp1_oe  = !dir_right;
  assign sp2_oe  = dir_right;
  assign sp1_out = sp1_oe && pulse;
  assign sp2_out = sp2_oe && pulse;
endmodule

// File: rtl/cascade_start_ctl_chk.sv
module cascade_start_ctl_chk #(
  parameter int WINDOW = 289,
  parameter int LEAD   = 13
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      dir_right,
  input logic                      line_strobe,
  input logic                      sample_start,
  input logic                      sp1_out,
  input logic                      sp1_oe,
  input logic                      sp2_out,
  input logic                      sp2_oe,
  input logic                      capture_en,
  input logic [$clog2(WINDOW)-1:0] cap_slot
);
  localparam int CW = $clog2(WINDOW);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic pls;
  assign pls = sp1_out | sp2_out;

  p_pin_roles_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dir_right |-> (!sp1_out && sp2_oe));
  p_pin_roles_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_right |-> (!sp2_out && sp1_oe));
  p_pulse_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pls) && capture_en) |-> (cap_slot == LAST));
  p_pulse_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pls |-> capture_en);
  p_window_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && cap_slot == LAST && !sample_start) |=> !capture_en);
  p_strobe_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_strobe |=> (!capture_en && !pls));
  p_slot_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && $past(capture_en) && !$past(sample_start)) |->
      (cap_slot == $past(cap_slot) + 1'b1));
  p_slot_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture_en) |-> (cap_slot == '0));
endmodule

bind cascade_start_ctl cascade_start_ctl_chk #(.WINDOW(WINDOW), .LEAD(LEAD)) chk_i (
  .clk(clk), .rst_n(rst_n), .dir_right(dir_right), .line_strobe(line_strobe),
  .sample_start(sample_start), .sp1_out(sp1_out), .sp1_oe(sp1_oe),
  .sp2_out(sp2_out), .sp2_oe(sp2_oe), .capture_en(capture_en), .cap_slot(cap_slot)
);

// File: tb/cascade_start_ctl_tb_top.sv
`timescale 1ns/1ps
module cascade_start_ctl_tb_top;
  localparam int W = 7;
  localparam int LD = 3;
  localparam int N = 3;

  logic clk = 0, rst_n = 0, dir_right = 1, line_strobe = 0, sample_start = 0;
  always #5 clk = ~clk;

  logic p1_in [N], p2_in [N], o1 [N], e1 [N], o2 [N], e2 [N], cap [N];
  logic [2:0] slot [N];
  logic link [N-1];

  assign p1_in[0]   = 1'b1;
  assign p2_in[N-1] = 1'b1;

  for (genvar k = 0; k < N - 1; k++) begin : g_link
    assign link[k]    = e2[k] ? o2[k] : (e1[k+1] ? o1[k+1] : 1'b0);
    assign p2_in[k]   = link[k];
    assign p1_in[k+1] = link[k];
  end

  for (genvar k = 0; k < N; k++) begin : g_chip
    if (k == 0) begin : g_dut
      cascade_start_ctl #(.WINDOW(W), .LEAD(LD)) dut_i (
        .clk(clk), .rst_n(rst_n), .dir_right(dir_right), .line_strobe(line_strobe),
        .sample_start(sample_start), .sp1_in(p1_in[k]), .sp2_in(p2_in[k]),
        .sp1_out(o1[k]), .sp1_oe(e1[k]), .sp2_out(o2[k]), .sp2_oe(e2[k]),
        .capture_en(cap[k]), .cap_slot(slot[k]));
    end else begin : g_peer
      cascade_start_ctl #(.WINDOW(W), .LEAD(LD)) peer_i (
        .clk(clk), .rst_n(rst_n), .dir_right(dir_right), .line_strobe(line_strobe),
        .sample_start(sample_start), .sp1_in(p1_in[k]), .sp2_in(p2_in[k]),
        .sp1_out(o1[k]), .sp1_oe(e1[k]), .sp2_out(o2[k]), .sp2_oe(e2[k]),
        .capture_en(cap[k]), .cap_slot(slot[k]));
    end
  end

  typedef struct {
    logic [N-1:0] cap;
    logic [N-1:0] pls;
    int           slot;
    string        tag;
  } exp_t;

  exp_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push_idle(input string tag);
    exp_t e;
    e.cap = '0; e.pls = '0; e.slot = 0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_data(input int c, input string tag);
    exp_t e;
    int p, chip, s;
    p = c / W;
    s = c % W;
    chip = dir_right ? p : N - 1 - p;
    e.cap = '0; e.pls = '0;
    e.cap[chip] = 1'b1;
    e.pls[chip] = (s >= W - LD - 1) && (s <= W - 2);
    e.slot = s; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic run_line(input int words, input bit abort, input string tag);
    line_strobe = 1; step; line_strobe = 0;
    sample_start = 1; step; sample_start = 0;
    for (int c = 0; c < words; c++) begin
      push_data(c, tag);
      if (abort && c == words - 1) line_strobe = 1;
      step;
    end
    line_strobe = 0;
    for (int i = 0; i < 3; i++) begin
      push_idle(abort ? "R7" : "R6");
      step;
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        logic [N-1:0] ac, ap;
        e = q.pop_front();
        for (int k = 0; k < N; k++) begin
          ac[k] = cap[k];
          ap[k] = dir_right ? o2[k] : o1[k];
        end
        chk(ac == e.cap, {e.tag, " capture owner"}, int'(ac), int'(e.cap));
        chk(ap == e.pls, {e.tag, "/R5 next-chip pulse"}, int'(ap), int'(e.pls));
        for (int k = 0; k < N; k++)
          if (e.cap[k]) chk(int'(slot[k]) == e.slot, {e.tag, "/R8 slot"}, int'(slot[k]), e.slot);
        for (int k = 0; k < N - 1; k++)
          chk(!(e2[k] && e1[k+1]), "R1/R2 pin contention", 1, 0);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (2) step;
    // R10: reset state
    for (int k = 0; k < N; k++) begin
      chk(cap[k] == 0, "R10 capture after reset", int'(cap[k]), 0);
      chk((o1[k] | o2[k]) == 0, "R10 pulse after reset", int'(o1[k] | o2[k]), 0);
    end
    rst_n = 1;
    step;
    // R9: high start inputs without a sampling start are ignored
    for (int i = 0; i < 5; i++) begin push_idle("R9"); step; end

    // R1: right shift roles, then a full chained line (R3, R4)
    dir_right = 1; step;
    for (int k = 0; k < N; k++) begin
      chk(e1[k] == 0 && e2[k] == 1, "R1 pin roles", int'({e1[k], e2[k]}), 1);
    end
    run_line(N * W, 0, "R3/R4 right");

    // R2: left shift roles, then a full chained line
    dir_right = 0; step;
    for (int k = 0; k < N; k++) begin
      chk(e1[k] == 1 && e2[k] == 0, "R2 pin roles", int'({e1[k], e2[k]}), 2);
    end
    run_line(N * W, 0, "R3/R4 left");

    // R7: strobe during the head chip's pulse cancels head and armed chip
    dir_right = 1; step;
    run_line(5, 1, "R7 abort");
    for (int i = 0; i < 4; i++) begin push_idle("R9 after abort"); step; end

    // second left line after the abort
    dir_right = 0; step;
    run_line(N * W, 0, "R8 left repeat");

    while (q.size() > 0) step;
    step;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule